// File: doc/BRIEF.md
# Cascaded 32-bit Capture Timer

This block joins two 16-bit timer halves into one free-running 32-bit counter with a 32-bit timestamp capture. The low half counts every clock. When it rolls over it emits a one-cycle overflow pulse, and that pulse is the count enable of the high half. Because the pulse is registered, the high half moves one clock after the low half has wrapped.

A single capture event is seen by both halves. The low half always latches its count on the event edge. The high half can latch on the same edge. It can instead latch one clock later when the delay control is set, which makes up for its one-clock lag. With the delay set, an event that falls exactly on the low-half wrap still yields a consistent 32-bit value. With the delay clear, the classic torn value appears at the wrap. The joined timestamp is presented together with a one-cycle valid strobe.

Top module: `cascade_capture`

## Requirements
- R1: During reset and on the first cycle after it, cap_valid is 0 and cap_value is 0. Both counter halves restart from 0.
- R2: The low half counts up by one on every clock after reset and wraps from 0xFFFF to 0x0000. A capture with delay taken on consecutive cycles across the wrap reads 0x0000FFFF and then 0x00010000.
- R3: The high half increments exactly one clock after the cycle in which the low half reads 0xFFFF, and it is otherwise constant.
- R4: An event sampled high on clock edge E produces cap_valid high for exactly the one cycle that follows edge E+1. No strobe is produced without an event.
- R5: With hi_dly_en high on the event cycle, cap_value equals the number of clocks since reset release at the event cycle, modulo 2^32. This also holds when the low half reads 0x0000.
- R6: With hi_dly_en low on the event cycle, cap_value[31:16] is the high half as it stands in the event cycle. At n = k*65536 (k > 0) this reads k-1, which is the torn value.
- R7: cap_value changes only on the edge that raises cap_valid, and it holds its value in between.
- R8: Events on consecutive cycles each produce their own strobe and their own correct value, in order.
- R9: hi_dly_en is sampled together with each event, so consecutive events may use different modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_evt | input | 1 | Capture event, sampled on the rising clock edge |
| hi_dly_en | input | 1 | 1 = the high half captures one clock late, to compensate for its lag |
| cap_value | output | 32 | Joined timestamp {high, low} |
| cap_valid | output | 1 | One-cycle strobe marking a new cap_value |

## Verification
A wrong counter or capture state shows up in the next captured timestamp, two clocks after the event. For that reason events are placed densely at random points and directly on the wrap cycles, and each is compared with a 32-bit reference count. A fault in the overflow pulse or in the high-half enable only appears when an event lands within a clock of a wrap. The directed events at the wrap, taken both with and without the delay, expose such a fault within that one capture. A lost or doubled strobe is visible one cycle after it should have occurred, because each strobe is checked on its cycle and on the cycle after it.

// File: rtl/cascade_capture.sv
module cascade_capture #(
  parameter int HALF_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_evt,
  input  logic                  hi_dly_en,
  output logic [2*HALF_W-1:0]   cap_value,
  output logic                  cap_valid
);

  localparam logic [HALF_W-1:0] HALF_MAX = '1;
  localparam logic [HALF_W-1:0] HALF_ONE = {{(HALF_W-1){1'b0}}, 1'b1};

  logic [HALF_W-1:0] lo_cnt, hi_cnt;
  logic [HALF_W-1:0] lo_stg, hi_stg;
  logic              ovf, evt_q, dly_q;
  logic [HALF_W-1:0] hi_pick;

  assign hi_pick = dly_q ? hi_cnt : hi_stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt    <= '0;
      hi_cnt    <= '0;
      ovf       <= 1'b0;
      evt_q     <= 1'b0;
      dly_q     <= 1'b0;
      lo_stg    <= '0;
      hi_stg    <= '0;
      cap_value <= '0;
      cap_valid <= 1'b0;
    end else begin
      lo_cnt <= lo_cnt + HALF_ONE;
      ovf    <= (lo_cnt == HALF_MAX);
      if (ovf) hi_cnt <= hi_cnt + HALF_ONE;
      evt_q <= cap_evt;
      if (cap_evt) begin
        lo_stg <= lo_cnt;
        hi_stg <= hi_cnt;
        dly_q  <= hi_dly_en;
      end
      cap_valid <= evt_q;
      if (evt_q) cap_value <= {hi_pick, lo_stg};
    end
  end

endmodule

module cascade_capture_chk #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cap_evt,
  input logic                hi_dly_en,
  input logic [2*HALF_W-1:0] cap_value,
  input logic                cap_valid,
  input logic [HALF_W-1:0]   lo_cnt,
  input logic [HALF_W-1:0]   hi_cnt
);
  localparam logic [HALF_W-1:0] HALF_MAX = '1;

  p_lo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lo_cnt == $past(lo_cnt) + 1'b1));

  p_hi_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt == HALF_MAX) |=> ##1 (hi_cnt == $past(hi_cnt, 2) + 1'b1));

  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_cnt != '0) |=> $stable(hi_cnt));

  p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ##1 cap_valid);

  p_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> ##1 !cap_valid);

  p_low_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> ##1 (cap_value[HALF_W-1:0] == $past(lo_cnt, 2)));

  p_high_undelayed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !hi_dly_en) |=> ##1 (cap_value[2*HALF_W-1:HALF_W] == $past(hi_cnt, 2)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |-> $stable(cap_value));
endmodule

bind cascade_capture cascade_capture_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .hi_dly_en(hi_dly_en),
  .cap_value(cap_value), .cap_valid(cap_valid),
  .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
);

// File: tb/cascade_capture_bench.sv
module cascade_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_evt = 1'b0;
  logic        hi_dly_en = 1'b0;
  logic [31:0] cap_value;
  logic        cap_valid;
  logic [31:0] ncyc;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  cascade_capture u_cascade_capture (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .hi_dly_en(hi_dly_en),
    .cap_value(cap_value), .cap_valid(cap_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ncyc <= '0;
    else        ncyc <= ncyc + 32'd1;
  end

  function automatic logic [31:0] exp_val(logic [31:0] n, logic dly);
    logic [31:0] hi;
    if (dly) return n;
    hi = (n == 0) ? 32'd0 : ((n - 32'd1) >> 16);
    return {hi[15:0], n[15:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wait_n(logic [31:0] target);
    while (ncyc != target) @(negedge clk);
  endtask

  task automatic fire(logic dly, string req);
    logic [31:0] n0, hold;
    cap_evt = 1'b1; hi_dly_en = dly; n0 = ncyc;
    @(negedge clk);
    cap_evt = 1'b0; hi_dly_en = ~dly;
    chk("R4 early", {31'd0, cap_valid}, 32'd0);
    @(negedge clk);
    chk("R4 strobe", {31'd0, cap_valid}, 32'd1);
    chk(req, cap_value, exp_val(n0, dly));
    hold = cap_value;
    @(negedge clk);
    chk("R4 single", {31'd0, cap_valid}, 32'd0);
    chk("R7 hold", cap_value, hold);
  endtask

  task automatic burst(logic d0, logic d1, string req);
    logic [31:0] n0;
    cap_evt = 1'b1; hi_dly_en = d0; n0 = ncyc;
    @(negedge clk);
    hi_dly_en = d1;
    @(negedge clk);
    cap_evt = 1'b0; hi_dly_en = 1'b0;
    chk({req, " first strobe"}, {31'd0, cap_valid}, 32'd1);
    chk({req, " first value"}, cap_value, exp_val(n0, d0));
    @(negedge clk);
    chk({req, " second strobe"}, {31'd0, cap_valid}, 32'd1);
    chk({req, " second value"}, cap_value, exp_val(n0 + 32'd1, d1));
    @(negedge clk);
    chk({req, " end"}, {31'd0, cap_valid}, 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, cap_valid}, 32'd0);
    chk("R1 value in reset", cap_value, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {31'd0, cap_valid}, 32'd0);
    chk("R1 value after reset", cap_value, 32'd0);
    fire(1'b1, "R5 early");
    fire(1'b0, "R6 early");
    while (ncyc < 32'd65300) begin
      repeat (1 + ($urandom % 300)) @(negedge clk);
      fire(1'($urandom % 2), "R5/R6 random");
    end
    wait_n(32'd65530);
    fire(1'b0, "R6 before wrap");
    wait_n(32'd65535);
    burst(1'b1, 1'b1, "R2 R5 R8 wrap delayed");
    wait_n(32'd65540);
    fire(1'b0, "R3 after wrap");
    wait_n(32'd131071);
    burst(1'b1, 1'b0, "R9 R6 torn at wrap");
    wait_n(32'd131080);
    burst(1'b0, 1'b1, "R8 R9 pair");
    repeat (20) begin
      repeat (1 + ($urandom % 40)) @(negedge clk);
      fire(1'($urandom % 2), "R5/R6 random late");
    end
    finish_up();
  end
endmodule